// File: doc/BRIEF.md
# TCP/UDP Header Exception Checker

This block looks at the start of a layer-4 segment and gives one exception code for each packet. Bytes arrive one per beat, starting at the first byte of the TCP or UDP header. Three side-band inputs travel with the packet:

- the protocol (TCP or UDP);
- the layer-4 length that the IP header implies;
- a pass/fail flag from an upstream checksum unit.

The block takes all three from the first byte of each packet.

The header is 8 bytes for UDP and 20 bytes for TCP. The block collects the port fields, the UDP length field and the TCP flag byte as they pass. It then reports a 4-bit code on a single-cycle valid pulse, in one of two cycles:

- the cycle after the final header byte is accepted; or
- the cycle after the end-of-packet byte, if the packet ends before the header is complete.

After the report, the block ignores the rest of the packet until its end-of-packet byte. The next valid byte then starts a new packet.

When several conditions hold, the code with the lowest number wins. Codes 5 to 7, 14 and 15 are never produced.

Top module: `l4_exc_checker`

## Requirements
- R1: While reset is asserted and in the cycle after it, `err_valid` is 0 and `err_code` is 0.
- R2: Each packet gives exactly one `err_valid` pulse. It comes in the cycle after the byte at index 19 (TCP) or index 7 (UDP) is accepted, or in the cycle after the `in_last` byte if that byte comes earlier. Bytes after the header give no further pulse.
- R3: Code 1 is reported when the packet ends before the whole header has arrived. In that case no other condition is considered.
- R4: Code 2 is reported when `in_csum_ok` is low on the first byte of a complete header. It takes priority over codes 3 and above.
- R5: Code 3 is reported for UDP when the big-endian length in bytes 4 and 5 differs from `in_ip_len`. TCP never gives code 3.
- R6: Code 4 is reported when the big-endian port in bytes 0 and 1 is zero, or the one in bytes 2 and 3 is zero.
- R7: Code 8 is reported for TCP when FIN is the only flag set. The flags are the low six bits of header byte 13: bit 0 FIN, bit 1 SYN, bit 2 RST, bit 3 PSH, bit 4 ACK, bit 5 URG. Bits 6 and 7 of that byte have no effect.
- R8: Code 9 is reported for TCP when none of the six flag bits is set.
- R9: For TCP, code 10 means FIN and RST are both set, 11 means SYN and URG, 12 means SYN and RST, and 13 means SYN and FIN. Other flags may also be set. When several of these hold, the lowest code is reported.
- R10: UDP never gives codes 8 to 13. A packet with no exception gives code 0.
- R11: Codes 5, 6, 7, 14 and 15 are never emitted.
- R12: Cycles with `in_valid` low are ignored, including their `in_last` and `in_data` values. They produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat is valid |
| in_data | input | 8 | Header/packet byte |
| in_last | input | 1 | This beat is the last byte of the packet |
| in_tcp | input | 1 | Protocol: 1 for TCP, 0 for UDP (taken from the first byte) |
| in_csum_ok | input | 1 | Upstream checksum passed (taken from the first byte) |
| in_ip_len | input | 16 | Layer-4 length implied by the IP header (taken from the first byte) |
| err_valid | output | 1 | One-cycle pulse carrying the packet's code |
| err_code | output | 4 | Exception code, valid while `err_valid` is high |

## Verification
The bench builds the block with its default header sizes: a 20-byte TCP header, an 8-byte UDP header, and the TCP flag byte at offset 13. With these sizes every one of the 64 flag patterns can be swept, and so can every truncation length from one byte up to one short of each header. The bench also covers every mix of zero ports, checksum state and UDP length match, which tests the code priority order. Idle beats carrying a stray `in_last` are placed inside packets, so the bench can see whether any of them would wrongly end or report a packet.

// File: rtl/l4chk_pkg.sv
package l4chk_pkg;

  typedef enum logic [3:0] {
    C_OK       = 4'd0,
    C_SHORT    = 4'd1,
    C_CSUM     = 4'd2,
    C_LEN      = 4'd3,
    C_PORT     = 4'd4,
    C_FIN_ONLY = 4'd8,
    C_NO_FLAGS = 4'd9,
    C_FIN_RST  = 4'd10,
    C_SYN_URG  = 4'd11,
    C_SYN_RST  = 4'd12,
    C_SYN_FIN  = 4'd13
  } l4_code_e;

  localparam int F_FIN = 0;
  localparam int F_SYN = 1;
  localparam int F_RST = 2;
  localparam int F_URG = 5;

  typedef struct packed {
    logic        tcp;
    logic        csum_ok;
    logic [15:0] ip_len;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [15:0] ulen;
    logic [5:0]  flags;
  } l4_fields_t;

endpackage

// File: rtl/l4_hdr_capture.sv
module l4_hdr_capture
  import l4chk_pkg::*;
#(
  parameter int TCP_HDR  = 20,
  parameter int UDP_HDR  = 8,
  parameter int FLAG_OFS = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_tcp,
  input  logic       in_csum_ok,
  input  logic [15:0] in_ip_len,
  output l4_fields_t fld_n,
  output logic       report,
  output logic       short_pkt
);
  localparam int CNT_W = $clog2(TCP_HDR + 1);

  logic [CNT_W-1:0] idx_q;
  logic             done_q;
  l4_fields_t       fld_q;
  logic [CNT_W-1:0] hdr_last;
  logic             at_end;

  // merge the current byte into the fields captured so far
  always_comb begin
    fld_n = fld_q;
    if (idx_q == CNT_W'(0)) begin
      fld_n.tcp        = in_tcp;
      fld_n.csum_ok    = in_csum_ok;
      fld_n.ip_len     = in_ip_len;
      fld_n.sport[15:8] = in_data;
    end
    if (idx_q == CNT_W'(1)) fld_n.sport[7:0]  = in_data;
    if (idx_q == CNT_W'(2)) fld_n.dport[15:8] = in_data;
    if (idx_q == CNT_W'(3)) fld_n.dport[7:0]  = in_data;
    if (idx_q == CNT_W'(4)) fld_n.ulen[15:8]  = in_data;
    if (idx_q == CNT_W'(5)) fld_n.ulen[7:0]   = in_data;
    if (idx_q == CNT_W'(FLAG_OFS)) fld_n.flags = in_data[5:0];
  end

  assign hdr_last  = fld_n.tcp ? CNT_W'(TCP_HDR - 1) : CNT_W'(UDP_HDR - 1);
  assign at_end    = (idx_q == hdr_last);
  assign report    = in_valid && !done_q && (at_end || in_last);
  assign short_pkt = in_valid && !done_q && in_last && !at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      done_q <= 1'b0;
      fld_q  <= '0;
    end else if (in_valid) begin
      if (!done_q) fld_q <= fld_n;
      if (in_last) begin
        idx_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (at_end) done_q <= 1'b1;
        else        idx_q  <= idx_q + CNT_W'(1);
      end
    end
  end

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= CNT_W'(TCP_HDR - 1));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(idx_q) && $stable(done_q));

endmodule

// File: rtl/l4_exc_classify.sv
module l4_exc_classify
  import l4chk_pkg::*;
(
  input  l4_fields_t f,
  input  logic       short_pkt,
  output l4_code_e   code
);
  logic fin, syn, rst_f, urg;

  assign fin   = f.flags[F_FIN];
  assign syn   = f.flags[F_SYN];
  assign rst_f = f.flags[F_RST];
  assign urg   = f.flags[F_URG];

  always_comb begin
    code = C_OK;
    if (short_pkt)                           code = C_SHORT;
    else if (!f.csum_ok)                     code = C_CSUM;
    else if (!f.tcp && f.ulen != f.ip_len)   code = C_LEN;
    else if (f.sport == '0 || f.dport == '0) code = C_PORT;
    else if (f.tcp) begin
      if (f.flags == 6'b000001)  code = C_FIN_ONLY;
      else if (f.flags == '0)    code = C_NO_FLAGS;
      else if (fin && rst_f)     code = C_FIN_RST;
      else if (syn && urg)       code = C_SYN_URG;
      else if (syn && rst_f)     code = C_SYN_RST;
      else if (syn && fin)       code = C_SYN_FIN;
    end
  end
endmodule

// File: rtl/l4_exc_checker.sv
module l4_exc_checker
  import l4chk_pkg::*;
#(
  parameter int TCP_HDR  = 20,
  parameter int UDP_HDR  = 8,
  parameter int FLAG_OFS = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_tcp,
  input  logic        in_csum_ok,
  input  logic [15:0] in_ip_len,
  output logic        err_valid,
  output logic [3:0]  err_code
);
  l4_fields_t fld_n;
  logic       report;
  logic       short_pkt;
  l4_code_e   code_n;

  l4_hdr_capture #(
    .TCP_HDR (TCP_HDR),
    .UDP_HDR (UDP_HDR),
    .FLAG_OFS(FLAG_OFS)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_tcp    (in_tcp),
    .in_csum_ok(in_csum_ok),
    .in_ip_len (in_ip_len),
    .fld_n     (fld_n),
    .report    (report),
    .short_pkt (short_pkt)
  );

  l4_exc_classify u_cls (
    .f        (fld_n),
    .short_pkt(short_pkt),
    .code     (code_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_code  <= 4'd0;
    end else begin
      err_valid <= report;
      err_code  <= report ? code_n : 4'd0;
    end
  end

  // R11
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code <= 4'd4 || (err_code >= 4'd8 && err_code <= 4'd13)));

  // R3
  short_wins_chk: assert property (@(posedge clk) disable iff (rst)
    report && short_pkt |=> err_valid && err_code == 4'd1);

  // R4
  csum_prio_chk: assert property (@(posedge clk) disable iff (rst)
    report && !short_pkt && !fld_n.csum_ok |=> err_code == 4'd2);

  // R10
  udp_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    report && !fld_n.tcp |=> err_code < 4'd8);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !err_valid);

endmodule

// File: tb/test_l4_exc_checker.sv
module test_l4_exc_checker;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_last, in_tcp, in_csum_ok;
  logic [7:0]  in_data;
  logic [15:0] in_ip_len;
  logic        err_valid;
  logic [3:0]  err_code;

  int checks = 0;
  int fails  = 0;
  int pk     = 0;
  int bad_codes = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  l4_exc_checker i_l4_exc_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_tcp(in_tcp), .in_csum_ok(in_csum_ok),
    .in_ip_len(in_ip_len), .err_valid(err_valid), .err_code(err_code)
  );

  // R11: watch every pulse for an illegal code
  always @(negedge clk)
    if (!rst && err_valid && ((err_code >= 4'd5 && err_code <= 4'd7) || err_code >= 4'd14))
      bad_codes++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(input bit tcp, input bit csum, input logic [15:0] ipl,
                                  input logic [15:0] sp, input logic [15:0] dp,
                                  input logic [15:0] ul, input logic [7:0] flg, input int n);
    int hdr = tcp ? 20 : 8;
    logic [5:0] f = flg[5:0];
    if (n < hdr) return 1;
    if (!csum) return 2;
    if (!tcp && ul != ipl) return 3;
    if (sp == 0 || dp == 0) return 4;
    if (!tcp) return 0;
    if (f == 6'b000001) return 8;
    if (f == 6'b000000) return 9;
    if (f[0] && f[2]) return 10;
    if (f[1] && f[5]) return 11;
    if (f[1] && f[2]) return 12;
    if (f[1] && f[0]) return 13;
    return 0;
  endfunction

  function automatic logic [7:0] pkt_byte(input int i, input bit tcp,
                                          input logic [15:0] sp, input logic [15:0] dp,
                                          input logic [15:0] ul, input logic [7:0] flg);
    case (i)
      0: return sp[15:8];
      1: return sp[7:0];
      2: return dp[15:8];
      3: return dp[7:0];
      4: return ul[15:8];
      5: return ul[7:0];
      default: return (tcp && i == 13) ? flg : 8'(i * 37 + 5);
    endcase
  endfunction

  // starts and ends at a negedge
  task automatic send(input bit tcp, input bit csum, input logic [15:0] ipl,
                      input logic [15:0] sp, input logic [15:0] dp,
                      input logic [15:0] ul, input logic [7:0] flg,
                      input int n, input string req);
    int hdr  = tcp ? 20 : 8;
    int rpos = (n < hdr) ? n - 1 : hdr - 1;
    int exp  = exp_code(tcp, csum, ipl, sp, dp, ul, flg, n);
    int nval = 0;
    int pos  = -1;
    int got  = -1;
    in_tcp = tcp; in_csum_ok = csum; in_ip_len = ipl;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && ((pk + i) % 3) == 0) begin
        // R12: idle beat with a stray last marker
        in_valid = 1'b0; in_last = 1'b1; in_data = 8'hA5;
        @(negedge clk);
        if (err_valid) nval++;
      end
      in_valid = 1'b1;
      in_data  = pkt_byte(i, tcp, sp, dp, ul, flg);
      in_last  = (i == n - 1);
      @(negedge clk);
      if (err_valid) begin nval++; pos = i; got = int'(err_code); end
    end
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    if (err_valid) nval++;
    chk(nval == 1, "R2", "pulse count", nval, 1);
    chk(pos == rpos, "R2", "pulse position", pos, rpos);
    chk(got == exp, req, "code", got, exp);
    pk++;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    in_tcp = 1'b0; in_csum_ok = 1'b1; in_ip_len = 16'd0;
    repeat (3) @(negedge clk);
    chk(err_valid == 1'b0, "R1", "valid in reset", int'(err_valid), 0);
    chk(err_code == 4'd0, "R1", "code in reset", int'(err_code), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(err_valid == 1'b0, "R1", "valid after reset", int'(err_valid), 0);

    // R7 R8 R9: every TCP flag pattern, top bits varied
    for (int f = 0; f < 64; f++) begin
      logic [7:0] fb = {2'(f), 6'(f)};
      string r = (f == 1) ? "R7" : (f == 0) ? "R8" : "R9";
      send(1'b1, 1'b1, 16'd40, 16'h1234, 16'h0050, 16'hBEEF, fb, 20 + (f % 5), r);
    end

    // R3: every truncation length, other faults present too
    for (int n = 1; n < 20; n++)
      send(1'b1, 1'b0, 16'd40, 16'h0000, 16'h0000, 16'h0000, 8'h00, n, "R3");
    for (int n = 1; n < 8; n++)
      send(1'b0, 1'b0, 16'd99, 16'h0000, 16'h0000, 16'h0001, 8'h00, n, "R3");

    // R4 R5 R6 R10: UDP checksum/length/port combinations
    for (int k = 0; k < 16; k++) begin
      bit cs = k[0];
      bit lm = k[1];
      logic [15:0] sp = k[2] ? 16'h0000 : 16'h0400;
      logic [15:0] dp = k[3] ? 16'h0000 : 16'h0001;
      string r = !cs ? "R4" : !lm ? "R5" : (k[3:2] != 0) ? "R6" : "R10";
      send(1'b0, cs, 16'd26, sp, dp, lm ? 16'd26 : 16'd27, 8'h00, 8 + 4 * (k % 2), r);
    end

    // R5 R6 R4: TCP ignores the length bytes
    for (int k = 0; k < 16; k++) begin
      bit cs = k[0];
      logic [15:0] sp = k[1] ? 16'h0000 : 16'h8000;
      logic [15:0] dp = k[2] ? 16'h0000 : 16'h00FF;
      logic [7:0]  fl = k[3] ? 8'h01 : 8'h10;
      string r = !cs ? "R4" : (k[2:1] != 0) ? "R6" : "R5";
      send(1'b1, cs, 16'd60, sp, dp, 16'h7777, fl, 20, r);
    end

    // R12: a long idle stretch with last asserted gives no pulse
    begin
      int stray = 0;
      in_valid = 1'b0; in_last = 1'b1; in_data = 8'hFF;
      repeat (10) begin @(negedge clk); if (err_valid) stray++; end
      in_last = 1'b0;
      chk(stray == 0, "R12", "pulses while idle", stray, 0);
    end
    // R10: a clean UDP packet after the idle stretch
    send(1'b0, 1'b1, 16'd8, 16'h0035, 16'h0035, 16'd8, 8'h00, 8, "R10");

    chk(bad_codes == 0, "R11", "illegal codes seen", bad_codes, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule